// File: doc/BRIEF.md
# Fixed-Interval Periodic Pulse Generator

This block turns a frequency-compensated time base into a periodic one-cycle strobe. A 32-bit phase accumulator adds a programmable addend on every enabled system clock. Each carry out of the accumulator counts as one timer tick. Tuning the addend sets the tick rate as a fraction of the system clock.

A down counter starts from a programmed interval. Each tick lowers it by a programmable tick period rather than by one. When the count reaches zero the block raises its output for one clock. On the next clock the counter refills from the interval. That refill costs one tick's worth of time, so software programs the desired period minus one tick period. For example, with a tick period of 5 ns, a 1 s period needs 999999995 and a 100 µs period needs 99995. Clearing the enable input freezes the block in a clean, reloaded state.

Top module: `interval_pulse_gen`

## Requirements
- R1: After reset the output pulse is low, and the accumulator and the tick strobe are cleared.
- R2: While enabled, the accumulator adds `addend` modulo 2^32 on every clock, starting from zero. A carry out of bit 31 produces a tick, registered one clock later. An addend of zero never produces a tick.
- R3: The counter changes only on a tick, and each tick lowers it by `tick_period`.
- R4: The pulse rises on the clock whose tick brings the count to zero, and it stays high for exactly one clock.
- R5: If the remaining count is less than or equal to `tick_period`, the tick sets the count to zero and fires the pulse. The counter never wraps below zero.
- R6: On the clock after a pulse, the counter reloads from `interval` and ignores any tick on that clock. With a tick on every clock, pulses are therefore `max(1, ceil(interval/tick_period)) + 1` clocks apart.
- R7: While `enable` is low, there are no pulses, the accumulator is held at zero, and the counter follows `interval`. After `enable` rises, counting starts from a fresh load.
- R8: A change to `interval` while counting affects only the next reload and leaves the current countdown alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run control; low holds the block idle and reloaded |
| interval | input | CNT_W | Value loaded into the down counter (desired period minus tick period) |
| tick_period | input | CNT_W | Amount removed from the count on every tick |
| addend | input | ACC_W | Value added to the accumulator every enabled clock |
| pulse_out | output | 1 | One-clock strobe when the countdown reaches zero |

## Verification
Say `enable` is first sampled high at edge e0. Then the first accumulator add happens at e0, and its carry becomes a registered tick after that edge. The counter acts on that tick at e1. A pulse therefore appears after the edge at which the tick that empties the count is applied, and the reload happens at the following edge. The bench updates its arithmetic expectation at each rising edge from the inputs held stable there. It compares `pulse_out` at the falling edge, so each comparison sees the result of exactly one edge. Spacing checks count falling edges between consecutive pulses, and those counts follow the same two-register path.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
    // Action taken by the down counter on a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_STEP,
        ACT_FIRE
    } ipg_act_e;
endpackage

// File: rtl/ipg_tick_gen.sv
module ipg_tick_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] addend,
    output logic             tick
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } tick_state_t;

    tick_state_t s_d, s_q;
    logic [ACC_W:0] sum_w;

    always_comb begin
        sum_w = {1'b0, s_q.acc} + {1'b0, addend};
        s_d   = s_q;
        if (!run) begin
            s_d = '0;
        end else begin
            s_d.acc  = sum_w[ACC_W-1:0];
            s_d.tick = sum_w[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/ipg_down_counter.sv
module ipg_down_counter
    import ipg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    input  logic [CNT_W-1:0] step,
    output logic             pulse,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    ipg_act_e   act_w;

    always_comb begin
        if (!run || s_q.pulse)  act_w = ACT_LOAD;
        else if (!tick)         act_w = ACT_HOLD;
        else if (s_q.cnt <= step) act_w = ACT_FIRE;
        else                    act_w = ACT_STEP;
    end

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        unique case (act_w)
            ACT_LOAD: s_d.cnt = interval;
            ACT_STEP: s_d.cnt = s_q.cnt - step;
            ACT_FIRE: begin
                s_d.cnt   = '0;
                s_d.pulse = 1'b1;
            end
            default:  s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse = s_q.pulse;
    assign count = s_q.cnt;
endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen #(
    parameter int ACC_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] interval,
    input  logic [CNT_W-1:0] tick_period,
    input  logic [ACC_W-1:0] addend,
    output logic             pulse_out
);
    logic             tick_w;
    logic [CNT_W-1:0] cnt_w;

    ipg_tick_gen #(.ACC_W(ACC_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable),
        .addend (addend),
        .tick   (tick_w)
    );

    ipg_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .tick     (tick_w),
        .interval (interval),
        .step     (tick_period),
        .pulse    (pulse_out),
        .count    (cnt_w)
    );
endmodule

// File: rtl/interval_pulse_gen_sva.sv
module interval_pulse_gen_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [CNT_W-1:0] interval,
    input logic [CNT_W-1:0] tick_period,
    input logic             tick_w,
    input logic [CNT_W-1:0] cnt_w,
    input logic             pulse_out
);
    p_one_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !pulse_out);

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pulse_out);

    p_fire_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !pulse_out && !tick_w) |=> !pulse_out);

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && enable) |=> (cnt_w == $past(interval)));

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !pulse_out && tick_w && cnt_w <= tick_period)
        |=> (pulse_out && cnt_w == '0));
endmodule

bind interval_pulse_gen interval_pulse_gen_sva #(.CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .interval    (interval),
    .tick_period (tick_period),
    .tick_w      (tick_w),
    .cnt_w       (cnt_w),
    .pulse_out   (pulse_out)
);

// File: tb/interval_pulse_gen_bench.sv
module interval_pulse_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] interval = '0;
    logic [31:0] tick_period = 32'd1;
    logic [31:0] addend = '0;
    logic        pulse_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    interval_pulse_gen u_interval_pulse_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .interval(interval),
        .tick_period(tick_period), .addend(addend), .pulse_out(pulse_out)
    );

    always #5 clk = ~clk;

    // Arithmetic expectation: adds since enable, consumed time since reload
    longint unsigned k_adds = 0;
    longint unsigned used = 0;
    longint unsigned lim = 0;
    bit m_tick = 1'b0;
    bit m_pulse = 1'b0;

    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            k_adds = 0; used = 0; m_tick = 1'b0; m_pulse = 1'b0;
            lim = interval;
        end else begin
            bit carry;
            carry = ((((k_adds + 1) * addend) >> 32) != ((k_adds * addend) >> 32));
            if (m_pulse) begin
                m_pulse = 1'b0; used = 0; lim = interval;
            end else if (m_tick) begin
                used = used + tick_period;
                if (used >= lim) m_pulse = 1'b1;
            end
            m_tick = carry;
            k_adds = k_adds + 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_case(input int iv, input int tp, input logic [31:0] ad,
                            input int ncyc, input string req);
        int last;
        int gaps;
        @(negedge clk);
        enable = 1'b0;
        interval = iv; tick_period = tp; addend = ad;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        last = -1; gaps = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            check(req, pulse_out, m_pulse);
            if (pulse_out) begin
                if (ad == 32'hFFFF_FFFF && last >= 0 && gaps == 0) begin
                    // R6: spacing with a tick on every clock
                    check("R6", c - last, ((iv == 0) ? 1 : (iv + tp - 1) / tp) + 1);
                    gaps++;
                end
                last = c;
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", pulse_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pulse_out, 0);

        // R7: disabled with a short interval and fast addend: silent
        interval = 0; tick_period = 5; addend = 32'hFFFF_FFFF; enable = 1'b0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            check("R7", pulse_out, 0);
        end

        // R2: zero addend never ticks, so no pulse ever
        run_case(0, 1, 32'h0, 30, "R2");

        // Sweep: R3/R4/R5 per-cycle against arithmetic expectation
        foreach (tick_period[i]) if (i < 0) ; // no-op keeps loops uniform
        for (int t = 0; t < 4; t++) begin
            int tp;
            tp = (t == 0) ? 1 : (t == 1) ? 2 : (t == 2) ? 3 : 5;
            for (int iv = 0; iv <= 12; iv++) begin
                run_case(iv, tp, 32'hFFFF_FFFF, 40, "R4");
                run_case(iv, tp, 32'h8000_0000, 40, "R3");
                run_case(iv, tp, 32'h5555_5556, 40, "R5");
            end
        end

        // R5: remaining 2 below step 5 -> saturate and fire
        run_case(7, 5, 32'hFFFF_FFFF, 30, "R5");

        // R7: restart gives the same sequence as a fresh run
        run_case(9, 2, 32'h8000_0000, 40, "R7");

        // R8: interval changed mid-countdown applies only at reload
        @(negedge clk);
        enable = 1'b0; interval = 20; tick_period = 1; addend = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            check("R8", pulse_out, m_pulse);
            if (c == 6) interval = 3;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule